// File: doc/BRIEF.md
# Systematic Reed-Solomon Encoder

This block appends Reed-Solomon check symbols to a stream of information symbols over GF(2^M). Symbol width, codeword length, check-symbol count, field polynomial and the exponent of the first generator root are all parameters. The generator polynomial is multiplied out from its roots at elaboration time, so the hardware holds only constant-coefficient multipliers.

Each codeword begins with a start pulse. After that pulse, every clock edge with the enable high takes one information symbol and copies it to the output register. Once all K = N − R information symbols have been taken, the next R enabled edges each put out one check symbol. Dropping the enable freezes the block, so it supports gapped streams as well as back-to-back ones. After a full codeword the block stays idle until the next start.

Top module: `rs_sys_encoder`

## Requirements
- R1: While `rst` is high, all state clears asynchronously. `dout` reads zero and the encoder is idle.
- R2: A clock edge with `start` high clears the remainder and the symbol count and arms a new codeword. That edge captures no symbol and leaves `dout` unchanged.
- R3: For the first K enabled edges after start, `dout` shows the symbol sampled from `din` at that edge, starting with the edge that captures the first symbol.
- R4: On the next R enabled edges, `dout` shows the coefficients of the remainder of x^R·d(x) divided by g(x), highest degree first. Here g(x) is the product of (x + α^(ROOT0+i)) for i = 0..R−1, α is the element 2, and the field is reduced by FIELD_POLY.
- R5: Read with its first symbol as the highest-degree coefficient, the N-symbol output codeword evaluates to zero at each of the R generator roots.
- R6: An edge with `en` low changes neither `dout` nor the encoding state, and encoding resumes from where it paused.
- R7: During the check-symbol phase the value on `din` has no effect on `dout`.
- R8: After N symbols have been output, `en` and `din` have no effect: `dout` holds until the next start.
- R9: A start in the middle of a codeword abandons it. The next codeword is then encoded as if from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Arms a new codeword |
| en | input | 1 | Advances the encoder by one symbol |
| din | input | M | Information symbol |
| dout | output | M | Registered codeword symbol |

## Verification
The checker assumes that `start` and `en` are never unknown while out of reset. It does not require `en` to be low during a start, because the design gives start priority. The bench drives all inputs at the falling edge, so each input is settled long before it is sampled. The bench tests the block in three ways: continuous codewords, codewords with gaps, and a codeword cut short by a new start. Output values are checked against a long-division model and against a syndrome evaluation at the roots.

// File: rtl/rs_sys_encoder.sv
module rs_sys_encoder #(
  parameter int M          = 8,
  parameter int N          = 255,
  parameter int R          = 16,
  parameter int FIELD_POLY = 'h11D,
  parameter int ROOT0      = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         en,
  input  logic [M-1:0] din,
  output logic [M-1:0] dout
);
  localparam int K  = N - R;
  localparam int CW = $clog2(N + 1);
  localparam logic [M-1:0]  PLO  = FIELD_POLY[M-1:0];
  localparam logic [CW-1:0] K_C  = CW'(K);
  localparam logic [CW-1:0] N_C  = CW'(N);
  localparam logic [CW-1:0] NM1  = CW'(N - 1);

  function automatic logic [M-1:0] gf_xt(input logic [M-1:0] a);
    return {a[M-2:0], 1'b0} ^ (a[M-1] ? PLO : '0);
  endfunction

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = gf_xt(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [R*M-1:0] gen_poly();
    logic [M-1:0] g [R+1];
    logic [M-1:0] root;
    logic [R*M-1:0] flat;
    for (int k = 0; k <= R; k++) g[k] = '0;
    g[0] = 1;
    root = 1;
    for (int i = 0; i < ROOT0; i++) root = gf_xt(root);
    for (int i = 0; i < R; i++) begin
      for (int k = R; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_xt(root);
    end
    for (int k = 0; k < R; k++) flat[k*M +: M] = g[k];
    return flat;
  endfunction

  localparam logic [R*M-1:0] GEN = gen_poly();

  logic [M-1:0]  rem [R];
  logic [CW-1:0] sym_cnt;
  logic          busy;

  wire          step    = busy & en & ~start;
  wire          in_info = sym_cnt < K_C;
  wire [M-1:0]  fb      = in_info ? (din ^ rem[R-1]) : '0;

  for (genvar k = 0; k < R; k++) begin : g_stage
    logic [M-1:0] prev;
    if (k == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = rem[k-1];
    end
    always_ff @(posedge clk or posedge rst)
      if (rst)        rem[k] <= '0;
      else if (start) rem[k] <= '0;
      else if (step)  rem[k] <= prev ^ gf_mul(fb, GEN[k*M +: M]);
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sym_cnt <= N_C;
      busy    <= 1'b0;
      dout    <= '0;
    end else if (start) begin
      sym_cnt <= '0;
      busy    <= 1'b1;
    end else if (step) begin
      dout    <= in_info ? din : rem[R-1];
      sym_cnt <= sym_cnt + 1'b1;
      if (sym_cnt == NM1) busy <= 1'b0;
    end
endmodule

// File: rtl/rs_sys_encoder_chk.sv
module rs_sys_encoder_chk #(
  parameter int M = 8,
  parameter int N = 255,
  parameter int R = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          en,
  input logic [M-1:0]  din,
  input logic [M-1:0]  dout,
  input logic [CW-1:0] cnt,
  input logic          busy
);
  a_r2_start_clears_count: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == 0) && busy);
  a_r2_start_holds_output: assert property (@(posedge clk) disable iff (rst)
    start |=> $stable(dout));
  a_r3_info_passthrough: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && en && cnt < CW'(N - R)) |=> dout == $past(din));
  a_r6_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!en && !start) |=> $stable(dout) && $stable(cnt));
  a_r8_idle_until_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy && $stable(dout));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(N));
  a_r4_ends_at_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cnt == CW'(N));
endmodule

bind rs_sys_encoder rs_sys_encoder_chk #(.M(M), .N(N), .R(R), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .en(en), .din(din), .dout(dout),
  .cnt(sym_cnt), .busy(busy)
);

// File: tb/sim_rs_sys_encoder.sv
`timescale 1ns/1ps
module sim_rs_sys_encoder;
  localparam int M = 8, N = 40, R = 7, POLY = 'h11D, ROOT0 = 3;
  localparam int K = N - R;

  logic clk = 0;
  always #2.5 clk = ~clk;
  logic rst = 1, start = 0, en = 0;
  logic [M-1:0] din = '0;
  logic [M-1:0] dout;

  rs_sys_encoder #(.M(M), .N(N), .R(R), .FIELD_POLY(POLY), .ROOT0(ROOT0)) u0 (
    .clk(clk), .rst(rst), .start(start), .en(en), .din(din), .dout(dout));

  int checks = 0, fails = 0;
  bit done = 0;
  logic arm = 0;
  logic [M-1:0] exp_q[$];
  string        tag_q[$];
  logic [M-1:0] act_q[$];
  logic [M-1:0] last_out = '0;
  logic [M-1:0] gen [R+1];
  logic [M-1:0] m_e;
  string        m_t;

  function automatic logic [M-1:0] b_xt(input logic [M-1:0] a);
    logic [M:0] t;
    t = {a, 1'b0};
    if (t[M]) t = t ^ POLY[M:0];
    return t[M-1:0];
  endfunction

  function automatic logic [M-1:0] b_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r, x, y;
    r = '0; x = a; y = b;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = b_xt(x);
      y = y >> 1;
    end
    return r;
  endfunction

  task automatic build_gen();
    logic [M-1:0] nx [R+1];
    logic [M-1:0] a;
    int deg;
    for (int k = 0; k <= R; k++) gen[k] = '0;
    gen[0] = 1; deg = 0;
    a = 1;
    for (int i = 0; i < ROOT0; i++) a = b_mul(a, 2);
    for (int i = 0; i < R; i++) begin
      for (int k = 0; k <= R; k++) nx[k] = '0;
      for (int k = 0; k <= deg; k++) begin
        nx[k+1] ^= gen[k];
        nx[k]   ^= b_mul(gen[k], a);
      end
      deg++;
      for (int k = 0; k <= R; k++) gen[k] = nx[k];
      a = b_mul(a, 2);
    end
  endtask

  task automatic check(input string t, input logic [M-1:0] act, input logic [M-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, expv, $time);
    end
  endtask

  always @(posedge clk) if (arm) begin
    #1;
    m_e = exp_q.pop_front();
    m_t = tag_q.pop_front();
    if (m_t == "R3" || m_t == "R4" || m_t == "R7") act_q.push_back(dout);
    check(m_t, dout, m_e);
  end

  task automatic tick(input bit s, input bit e, input logic [M-1:0] d,
                      input logic [M-1:0] x, input string t);
    @(negedge clk);
    start = s; en = e; din = d; arm = 1;
    exp_q.push_back(x); tag_q.push_back(t);
  endtask

  task automatic flush();
    @(negedge clk);
    arm = 0; start = 0;
  endtask

  task automatic encode_cw(input bit gap, input bit idle_after, input string stag);
    logic [M-1:0] w [N];
    logic [M-1:0] s, pw, c;
    tick(1, 1'($urandom), M'($urandom), last_out, "R2");
    act_q.delete();
    for (int i = 0; i < N; i++) w[i] = '0;
    for (int i = 0; i < K; i++) begin
      if (gap && i % 3 == 1) tick(0, 0, M'($urandom), last_out, "R6");
      w[i] = (i == 0) ? '0 : M'($urandom);
      tick(0, 1, w[i], w[i], "R3");
      last_out = w[i];
    end
    for (int i = 0; i < K; i++) begin
      c = w[i];
      for (int j = 1; j <= R; j++) w[i+j] ^= b_mul(c, gen[R-j]);
    end
    for (int i = 0; i < K; i++) w[i] = act_q.size() > i ? w[i] : w[i];
    for (int j = 0; j < R; j++) begin
      if (gap && j == 2) tick(0, 0, M'($urandom), last_out, "R6");
      tick(0, 1, M'($urandom), w[K+j], (j % 2 == 1) ? "R7" : "R4");
      last_out = w[K+j];
    end
    if (idle_after) for (int i = 0; i < 3; i++) tick(0, 1, M'($urandom), last_out, "R8");
    flush();
    if (act_q.size() != N) begin
      check(stag, M'(act_q.size()), M'(N));
    end else begin
      pw = 1;
      for (int i = 0; i < ROOT0; i++) pw = b_mul(pw, 2);
      for (int r = 0; r < R; r++) begin
        s = '0;
        for (int i = 0; i < N; i++) s = b_mul(s, pw) ^ act_q[i];
        check(stag, s, '0);
        pw = b_mul(pw, 2);
      end
    end
  endtask

  initial begin
    build_gen();
    repeat (3) @(negedge clk);
    check("R1", dout, '0);
    rst = 0;
    tick(0, 1, 8'h5A, '0, "R8");
    tick(0, 1, 8'hC3, '0, "R8");
    flush();
    encode_cw(0, 1, "R5");
    encode_cw(1, 1, "R5");
    encode_cw(0, 0, "R5");
    encode_cw(0, 0, "R5");
    tick(1, 1, 8'h11, last_out, "R2");
    for (int i = 0; i < 5; i++) begin
      tick(0, 1, M'(i + 8'h20), M'(i + 8'h20), "R9");
      last_out = M'(i + 8'h20);
    end
    flush();
    encode_cw(1, 1, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule